// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned WIDTH-bit integer by another over several clock cycles and returns a quotient and a remainder. A one-cycle `start` strobe captures `dividend` and `divisor`. The block then resolves one quotient bit per clock. At each step it shifts the partial remainder and quotient left together. It then adds the divisor back or subtracts it, depending on the sign the partial remainder had before that step. No restore happens inside the loop. A single correction cycle at the end adds the divisor once more if the partial remainder is still negative, so the remainder is always in range.

The partial remainder is held one bit wider than the operands, and its top bit is the sign. A zero divisor does not start the loop. The block finishes on the next clock with a flag raised, so it cannot hang. Results are registered. They stay unchanged until a later division completes. A new `start` is accepted in the same cycle that `done` is high.

Top module: `seq_nr_divider`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: When `start` is high, `busy` is low and `divisor` is non-zero, `busy` is high from the next cycle. On completion `quotient` equals floor(dividend / divisor), using the operands captured at that start.
- R3: For a non-zero divisor, `done` is high for exactly one cycle. That cycle comes WIDTH+1 clock edges after the edge that accepted `start`. `busy` is low in the `done` cycle.
- R4: On every non-zero-divisor completion, `remainder` equals dividend − quotient·divisor and is strictly less than the divisor. This includes cases where the final partial remainder needed the correction step.
- R5: A start with `divisor` equal to zero sets `div_by_zero` to 1, `quotient` to all ones and `remainder` to the captured dividend. `done` is high on the cycle right after the accepting edge, and `busy` never rises.
- R6: A `start` pulse while `busy` is high is ignored. The running division keeps its operands, its result and its WIDTH+1 latency.
- R7: `quotient`, `remainder` and `div_by_zero` change only at a `done` edge and hold between completions. A later non-zero-divisor completion clears `div_by_zero` to 0.
- R8: A `start` given in the `done` cycle is accepted, so divisions can run back to back with no idle cycle.
- R9: Corner operands give exact results: the all-ones dividend over 1, a dividend smaller than the divisor (quotient 0), all ones over all ones (quotient 1, remainder 0), and a zero dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division. Honoured only while `busy` is low |
| dividend | input | WIDTH | Unsigned dividend, sampled with `start` |
| divisor | input | WIDTH | Unsigned divisor, sampled with `start` |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |
| div_by_zero | output | 1 | Last completed division had a zero divisor |

## Verification
With a non-zero divisor, `busy` shows on the first cycle after the accepting edge. `done` and the new results show WIDTH+1 edges later, and with a zero divisor they show right after the accepting edge. Each scenario task drives `start` on a falling edge and counts falling edges until `done`. It samples all outputs there, midway between active edges. A latency that differs from the expected count is reported as a failure. After completion the task keeps sampling for a few more cycles to confirm that `done` dropped and the results held.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } nrd_state_e;

    // Per-cycle command from the sequencer to the datapath
    typedef struct packed {
        logic load;   // capture operands, clear partial remainder
        logic step;   // one shift and add/subtract iteration
        logic fix;    // final remainder correction and result write
        logic zero;   // zero-divisor completion
    } nrd_cmd_t;

endpackage

// File: rtl/nrd_control.sv
module nrd_control
    import nrd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     div_zero,
    output nrd_cmd_t cmd,
    output logic     busy
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    nrd_state_e state;
    logic [CW-1:0] iter;
    logic accept;

    assign accept = start && (state == ST_IDLE);

    always_comb begin
        cmd.load = accept && !div_zero;
        cmd.zero = accept && div_zero;
        cmd.step = (state == ST_RUN);
        cmd.fix  = (state == ST_FIX);
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd.load) begin
                        state <= ST_RUN;
                        iter  <= '0;
                    end
                end
                ST_RUN: begin
                    iter <= iter + 1'b1;
                    if (iter == LAST) state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nrd_datapath.sv
module nrd_datapath
    import nrd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  nrd_cmd_t     cmd,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done,
    output logic         div_by_zero
);
    localparam int AW = W + 1;

    logic [AW-1:0] acc;      // signed partial remainder, MSB is sign
    logic [W-1:0]  qreg;     // dividend shifting out, quotient shifting in
    logic [W-1:0]  dreg;

    logic [AW-1:0] shifted, dext, acc_next, acc_fixed;

    always_comb begin
        dext      = {1'b0, dreg};
        shifted   = {acc[W-1:0], qreg[W-1]};
        acc_next  = acc[W] ? (shifted + dext) : (shifted - dext);
        acc_fixed = acc[W] ? (acc + dext) : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc         <= '0;
            qreg        <= '0;
            dreg        <= '0;
            quotient    <= '0;
            remainder   <= '0;
            done        <= 1'b0;
            div_by_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cmd.load) begin
                acc  <= '0;
                qreg <= dividend;
                dreg <= divisor;
            end else if (cmd.step) begin
                acc  <= acc_next;
                qreg <= {qreg[W-2:0], ~acc_next[W]};
            end
            if (cmd.fix) begin
                quotient    <= qreg;
                remainder   <= acc_fixed[W-1:0];
                div_by_zero <= 1'b0;
                done        <= 1'b1;
            end else if (cmd.zero) begin
                quotient    <= '1;
                remainder   <= dividend;
                div_by_zero <= 1'b1;
                done        <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider
    import nrd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_by_zero
);
    nrd_cmd_t cmd;
    logic     dzero;

    assign dzero = (divisor == '0);

    nrd_control #(.W(WIDTH)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_zero (dzero),
        .cmd      (cmd),
        .busy     (busy)
    );

    nrd_datapath #(.W(WIDTH)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .done        (done),
        .div_by_zero (div_by_zero)
    );
endmodule

// File: rtl/nrd_checker.sv
module nrd_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);
    logic [W-1:0]   lat_dvd, lat_dsr;
    logic [15:0]    run_len;
    logic [2*W-1:0] recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_dvd <= '0;
            lat_dsr <= '0;
            run_len <= '0;
        end else if (start && !busy) begin
            lat_dvd <= dividend;
            lat_dsr <= divisor;
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 16'd1;
        end
    end

    always_comb recon = (2*W)'(quotient) * (2*W)'(lat_dsr) + (2*W)'(remainder);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (run_len == 16'(W + 1)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

    assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
        div_by_zero |-> (&quotient));

    assert_remainder_range_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (remainder < lat_dsr));

    assert_identity_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (recon == (2*W)'(lat_dvd)));

    assert_busy_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> (busy || done));
endmodule

bind seq_nr_divider nrd_checker #(.W(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/seq_nr_divider_test.sv
module seq_nr_divider_test;
    localparam int WIDTH = 8;
    localparam int LAT = WIDTH + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [WIDTH-1:0] dividend = '0;
    logic [WIDTH-1:0] divisor = '0;
    logic             busy, done, div_by_zero;
    logic [WIDTH-1:0] quotient, remainder;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    seq_nr_divider #(.WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the falling edge where done is seen.
    task automatic run_div(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                           input string tag, input logic disturb);
        int cyc;
        logic [WIDTH-1:0] eq, er;
        eq = (b == 0) ? '1 : WIDTH'(a / b);
        er = (b == 0) ? a : WIDTH'(a % b);
        dividend = a; divisor = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = b + 8'd3;
        cyc = 0;
        if (b != 0) check("R2", "busy after start", busy, 1);
        else        check("R5", "busy stays low", busy, 0);
        while (!done && cyc < 100) begin
            if (disturb && cyc == 3) begin
                check("R6", "busy during run", busy, 1);
                start = 1'b1; dividend = 8'd7; divisor = 8'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(b == 0 ? "R5" : "R3", "latency", cyc, b == 0 ? 0 : LAT);
        check("R3", "busy low at done", busy, 0);
        check(tag, "quotient", quotient, eq);
        check(b == 0 ? "R5" : "R4", "remainder", remainder, er);
        check(b == 0 ? "R5" : "R7", "div_by_zero", div_by_zero, b == 0);
    endtask

    task automatic hold_check(input int n);
        logic [WIDTH-1:0] q0, r0;
        logic f0;
        q0 = quotient; r0 = remainder; f0 = div_by_zero;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R3", "done single pulse", done, 0);
            check("R7", "quotient held", quotient, q0);
            check("R7", "remainder held", remainder, r0);
            check("R7", "flag held", div_by_zero, f0);
        end
    endtask

    task automatic test_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "quotient", quotient, 0);
        check("R1", "remainder", remainder, 0);
        check("R1", "div_by_zero", div_by_zero, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();

        run_div(8'd100, 8'd7,  "R2", 1'b0); hold_check(3);
        run_div(8'd200, 8'd13, "R2", 1'b0); hold_check(2);
        run_div(8'd255, 8'd16, "R4", 1'b0); hold_check(2);
        run_div(8'd129, 8'd128, "R4", 1'b0); hold_check(2);
        run_div(8'd255, 8'd1,  "R9", 1'b0); hold_check(2);
        run_div(8'd5,   8'd200, "R9", 1'b0); hold_check(2);
        run_div(8'd255, 8'd255, "R9", 1'b0); hold_check(2);
        run_div(8'd0,   8'd9,  "R9", 1'b0); hold_check(2);
        run_div(8'd77,  8'd0,  "R5", 1'b0); hold_check(3);
        run_div(8'd90,  8'd4,  "R7", 1'b0); hold_check(2);
        run_div(8'd250, 8'd3,  "R6", 1'b1); hold_check(LAT + 2);
        run_div(8'd143, 8'd11, "R8", 1'b0);
        run_div(8'd60,  8'd0,  "R8", 1'b0);
        run_div(8'd61,  8'd6,  "R8", 1'b0); hold_check(2);
        for (int a = 0; a < 256; a += 37)
            for (int b = 1; b < 256; b += 51) begin
                run_div(WIDTH'(a), WIDTH'(b), "R2", 1'b0);
            end
        hold_check(1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule